// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked requester inside the chip read and write an external asynchronous static RAM with a 15-bit word address, a 16-bit data word and two byte lanes. The host side uses a valid/ready handshake. Each request carries an address, write data, a per-lane mask and a write flag. Reads come back on a data bus qualified by a one-cycle valid pulse.

On the memory side the controller drives the active-low chip select, write strobe, output enable and the two lane enables. The data bus is split into an output word, a driver enable and an input word, so the pad ring can build the tri-state buffer.

Each access is built from phases whose lengths are counted in clock cycles. The counts are derived from a clock-period parameter and the memory's nanosecond limits. Each count is the limit divided by the period, rounded up, and never less than one. With the default 8 ns clock:

| Phase | Cycles |
|---|---|
| Write setup | 1 |
| Write pulse | 2 |
| Write recovery | 1 |
| Read access | 2 |

Top module: `sram_ctrl`

## Requirements
- R1: After reset, the outputs are in the idle state: `req_ready` is 1; chip select, write strobe, output enable and both lane enables are 1 (inactive); `sram_dq_oe` is 0; and `rsp_valid` is 0.
- R2: A write holds chip select low and output enable high for the whole access. The write strobe is low for at least 10 ns. The write data is driven and stable for at least 8 ns before the write strobe rises. The word then holds the new data on the enabled lanes and its old data on the others.
- R3: Mask bit 0 selects data bits 7:0 and drives `sram_lb_n` low. Mask bit 1 selects bits 15:8 and drives `sram_ub_n` low. A write with mask 00 changes no stored data.
- R4: A read holds chip select and output enable low, with the write strobe high, for ceil(15 ns / period) cycles. The bus is captured on the following edge, and `rsp_valid` is high for exactly one cycle. With the default period, `rsp_valid` is seen in the third cycle after the accepting edge.
- R5: `sram_dq_oe` is high only while output enable is high and has been high for at least one earlier cycle. It is never high while the memory is driving the bus.
- R6: The write strobe is the first of the write-enabling signals to rise, while chip select is still low. The address is stable for as long as chip select is low.
- R7: `req_ready` is low for the whole access. With the default period that is four cycles for a write and two for a read. A request raised while `req_ready` is low has no effect, and the controller returns to idle after every access.
- R8: In read data, a lane whose mask bit is 0 is returned as zero, whatever the bus carries on that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 = low byte, bit 1 = high byte |
| rsp_data | output | 16 | Read data; disabled lanes are zero |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| sram_addr | output | 15 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Low lane enable, active low |
| sram_ub_n | output | 1 | High lane enable, active low |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Driver enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from the memory bus |

## Verification
The bench's memory model measures every write pulse and the data-stable time before the strobe rises. A controller that shortens the pulse counts, or changes data inside the pulse, is reported there. It also flags any cycle in which the controller drives while the memory is driving, which a missing turnaround cycle would cause. Partial-lane writes followed by full reads expose a swapped or ignored lane enable, and the model puts a marker pattern on disabled lanes so that unmasked capture shows up in the read data. A request held during a busy write exposes a controller that accepts work outside idle. Counting cycles to `rsp_valid` and to `req_ready` catches a phase counter that is off by one.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSET   = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WREC   = 3'd3,
        ST_RACC   = 3'd4
    } sram_st_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } sram_strobe_t;

    localparam sram_strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic sram_strobe_t strobe_of(input sram_st_e s);
        sram_strobe_t p;
        p = STROBE_IDLE;
        case (s)
            ST_WSET:   p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            ST_WPULSE: p = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WREC:   p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            ST_RACC:   p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            default:   p = STROBE_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int SET_CYC = 1,
    parameter int PUL_CYC = 2,
    parameter int REC_CYC = 1,
    parameter int RD_CYC  = 2,
    parameter int CW      = 2,
    parameter int NLANE   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_wr,
    input  logic [NLANE-1:0] start_mask,
    output logic             idle,
    output sram_strobe_t     pins,
    output logic [NLANE-1:0] be_n,
    output logic             capture
);
    sram_st_e      st_q, st_nx;
    logic          tm_load, tm_done;
    logic [CW-1:0] tm_val;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val), .done(tm_done)
    );

    always_comb begin
        st_nx   = st_q;
        tm_load = 1'b0;
        tm_val  = '0;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: if (start) begin
                tm_load = 1'b1;
                if (start_wr) begin
                    st_nx  = ST_WSET;
                    tm_val = CW'(SET_CYC - 1);
                end else begin
                    st_nx  = ST_RACC;
                    tm_val = CW'(RD_CYC - 1);
                end
            end
            ST_WSET: if (tm_done) begin
                st_nx   = ST_WPULSE;
                tm_load = 1'b1;
                tm_val  = CW'(PUL_CYC - 1);
            end
            ST_WPULSE: if (tm_done) begin
                st_nx   = ST_WREC;
                tm_load = 1'b1;
                tm_val  = CW'(REC_CYC - 1);
            end
            ST_WREC: if (tm_done) st_nx = ST_IDLE;
            ST_RACC: if (tm_done) begin
                st_nx   = ST_IDLE;
                capture = 1'b1;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            pins <= STROBE_IDLE;
            be_n <= '1;
        end else begin
            st_q <= st_nx;
            pins <= strobe_of(st_nx);
            if (st_q == ST_IDLE && start)
                be_n <= ~start_mask;
            else if (st_nx == ST_IDLE)
                be_n <= '1;
        end
    end

    assign idle = (st_q == ST_IDLE);
endmodule

// File: rtl/sram_lane_cap.sv
module sram_lane_cap #(
    parameter int NLANE  = 2,
    parameter int LANE_W = 8,
    localparam int DW    = NLANE * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [NLANE-1:0] be_n,
    input  logic [DW-1:0]    dq_i,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (capture)
                lane_q <= be_n[l] ? '0 : dq_i[l*LANE_W +: LANE_W];
        end
        assign rdata[l*LANE_W +: LANE_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= capture;
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS = 8,
    parameter int AW     = 15,
    parameter int NLANE  = 2,
    parameter int LANE_W = 8,
    parameter int T_WP   = 10,
    parameter int T_SD   = 8,
    parameter int T_WC   = 15,
    parameter int T_AA   = 15,
    parameter int T_OE   = 7,
    parameter int T_HZ   = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [AW-1:0]            req_addr,
    input  logic [NLANE*LANE_W-1:0]  req_wdata,
    input  logic [NLANE-1:0]         req_mask,
    output logic [NLANE*LANE_W-1:0]  rsp_data,
    output logic                     rsp_valid,
    output logic [AW-1:0]            sram_addr,
    output logic                     sram_ce_n,
    output logic                     sram_we_n,
    output logic                     sram_oe_n,
    output logic                     sram_lb_n,
    output logic                     sram_ub_n,
    output logic [NLANE*LANE_W-1:0]  sram_dq_o,
    output logic                     sram_dq_oe,
    input  logic [NLANE*LANE_W-1:0]  sram_dq_i
);
    localparam int DW      = NLANE * LANE_W;
    localparam int SET_CYC = ns2cyc(T_HZ, CLK_NS);
    localparam int PUL_CYC = imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_SD, CLK_NS));
    localparam int REC_CYC = imax(1, ns2cyc(T_WC, CLK_NS) - PUL_CYC - SET_CYC);
    localparam int RD_CYC  = imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_OE, CLK_NS));
    localparam int MAXC    = imax(imax(SET_CYC, PUL_CYC), imax(REC_CYC, RD_CYC));
    localparam int CW      = imax(1, $clog2(MAXC + 1));

    logic             accept, idle;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    sram_strobe_t     pins;
    logic [NLANE-1:0] be_n;
    logic             capture;

    assign req_ready = idle;
    assign accept    = req_valid & idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    sram_seq #(
        .SET_CYC(SET_CYC), .PUL_CYC(PUL_CYC), .REC_CYC(REC_CYC),
        .RD_CYC(RD_CYC), .CW(CW), .NLANE(NLANE)
    ) u_seq (
        .clk(clk), .rst(rst), .start(accept), .start_wr(req_write),
        .start_mask(req_mask), .idle(idle), .pins(pins), .be_n(be_n),
        .capture(capture)
    );

    sram_lane_cap #(.NLANE(NLANE), .LANE_W(LANE_W)) u_cap (
        .clk(clk), .rst(rst), .capture(capture), .be_n(be_n),
        .dq_i(sram_dq_i), .rdata(rsp_data), .rvalid(rsp_valid)
    );

    assign sram_addr  = addr_q;
    assign sram_dq_o  = wdata_q;
    assign sram_ce_n  = pins.ce_n;
    assign sram_we_n  = pins.we_n;
    assign sram_oe_n  = pins.oe_n;
    assign sram_dq_oe = pins.dq_oe;
    assign sram_lb_n  = be_n[0];
    assign sram_ub_n  = be_n[NLANE-1];
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS = 8,
    parameter int T_WP   = 10,
    parameter int AW     = 15,
    parameter int DW     = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] sram_addr,
    input logic          sram_ce_n,
    input logic          sram_we_n,
    input logic          sram_oe_n,
    input logic [DW-1:0] sram_dq_o,
    input logic          sram_dq_oe
);
    localparam int WP_MIN = ns2cyc(T_WP, CLK_NS);

    logic [7:0] we_lo;
    always_ff @(posedge clk) begin
        if (rst)               we_lo <= '0;
        else if (!sram_we_n)   we_lo <= (we_lo == 8'hFF) ? we_lo : we_lo + 8'd1;
        else                   we_lo <= '0;
    end

    AST_DRV_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (sram_oe_n && $past(sram_oe_n))); // R5
    AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n)); // R2
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_dq_o)); // R2
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (int'(we_lo) >= WP_MIN)); // R2
    AST_WE_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> !sram_ce_n); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R6
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R4
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && !sram_dq_oe)); // R7
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .CLK_NS(CLK_NS), .T_WP(T_WP), .AW(AW), .DW(NLANE*LANE_W)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_data;
    logic [14:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;
    logic [15:0] sram_dq_o;
    logic [15:0] sram_dq_i = 16'h5A5A;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: storage plus write-timing and contention monitor
    logic [15:0] mem [int];
    logic [15:0] shadow [int];
    bit          act_q = 0;
    int          pw = 0, ds = 0;
    logic [15:0] dlast = '0;
    logic [14:0] alast = '0;
    logic [1:0]  llast = '0;

    function automatic logic [15:0] peek(input int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        bit act;
        logic [15:0] w;
        act = !sram_ce_n && !sram_we_n && (!sram_lb_n || !sram_ub_n);
        if (sram_dq_oe && !sram_ce_n && !sram_oe_n && sram_we_n) begin
            total++; bad++;
            $display("FAIL R5 bus contention actual=1 expected=0");
        end
        if (act) begin
            if (!act_q) begin pw = 0; ds = 0; end
            pw++;
            if (sram_dq_oe && (ds == 0 || sram_dq_o == dlast)) ds++;
            else ds = 0;
            dlast = sram_dq_o; alast = sram_addr; llast = {!sram_ub_n, !sram_lb_n};
        end else if (act_q) begin
            check("R2 pulse width ok", 32'(pw * CLK_NS >= 10), 32'd1);
            check("R2 data setup ok", 32'(ds * CLK_NS >= 8), 32'd1);
            check("R6 strobe ends first", 32'(sram_ce_n), 32'd0);
            w = peek(int'(alast));
            if (llast[0]) w[7:0]  = dlast[7:0];
            if (llast[1]) w[15:8] = dlast[15:8];
            mem[int'(alast)] = w;
        end
        act_q = act;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            w = peek(int'(sram_addr));
            sram_dq_i[7:0]  <= sram_lb_n ? 8'hA5 : w[7:0];
            sram_dq_i[15:8] <= sram_ub_n ? 8'hA5 : w[15:8];
        end else
            sram_dq_i <= 16'h5A5A;
    end

    // one access; returns cycles with ready low and cycle of rsp_valid
    task automatic do_op(input bit wr, input logic [1:0] m, input logic [14:0] a,
                         input logic [15:0] d, output int busy, output int rv_at,
                         output logic [15:0] rd);
        int n;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_mask = m; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        check("R3 lane enables", {30'd0, sram_ub_n, sram_lb_n}, {30'd0, ~m});
        busy = 0; rv_at = 0; rd = '0; n = 1;
        while (n < 40) begin
            if (!req_ready) busy++;
            if (rsp_valid) begin rv_at = n; rd = rsp_data; end
            if (req_ready) break;
            @(negedge clk); n++;
        end
        if (wr) begin
            logic [15:0] s;
            s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
            if (m[0]) s[7:0] = d[7:0];
            if (m[1]) s[15:8] = d[15:8];
            shadow[int'(a)] = s;
        end
    endtask

    function automatic logic [15:0] expect_rd(input logic [1:0] m, input logic [14:0] a);
        logic [15:0] s;
        s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (!m[0]) s[7:0] = 8'h00;
        if (!m[1]) s[15:8] = 8'h00;
        return s;
    endfunction

    // {write, mask[1:0], addr[14:0], data[15:0]}
    localparam logic [33:0] VEC [0:9] = '{
        {1'b1, 2'b11, 15'h0000, 16'h1234},
        {1'b1, 2'b11, 15'h7FFF, 16'hABCD},
        {1'b1, 2'b01, 15'h0010, 16'h00EE},
        {1'b1, 2'b10, 15'h0010, 16'h7700},
        {1'b1, 2'b00, 15'h7FFF, 16'h0000},
        {1'b0, 2'b11, 15'h0000, 16'h0000},
        {1'b0, 2'b11, 15'h7FFF, 16'h0000},
        {1'b0, 2'b11, 15'h0010, 16'h0000},
        {1'b0, 2'b01, 15'h7FFF, 16'h0000},
        {1'b0, 2'b10, 15'h0000, 16'h0000}
    };

    initial begin
        int busy, rv_at;
        logic [15:0] rd;
        int wr_busy, rd_busy;
        wr_busy = cyc(7) + cyc(10) + ((cyc(15) - cyc(10) - cyc(7)) < 1 ? 1 : (cyc(15) - cyc(10) - cyc(7)));
        rd_busy = cyc(15);

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 strobes", {28'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 32'hE);
        check("R1 lanes", {30'd0, sram_ub_n, sram_lb_n}, 32'h3);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < 10; i++) begin
            bit wr;
            wr = VEC[i][33];
            do_op(wr, VEC[i][32:31], VEC[i][30:16], VEC[i][15:0], busy, rv_at, rd);
            if (wr) begin
                check("R7 write busy cycles", 32'(busy), 32'(wr_busy));
                check("R4 no rsp on write", 32'(rv_at), 32'd0);
            end else begin
                check("R7 read busy cycles", 32'(busy), 32'(rd_busy));
                check("R4 rsp_valid cycle", 32'(rv_at), 32'(rd_busy + 1));
                check("R8 R2 read data", {16'd0, rd}, {16'd0, expect_rd(VEC[i][32:31], VEC[i][30:16])});
            end
        end

        // R3: mask 00 write left word 7FFF as ABCD
        do_op(0, 2'b11, 15'h7FFF, 16'h0, busy, rv_at, rd);
        check("R3 mask 00 no change", {16'd0, rd}, 32'h0000ABCD);

        // R7: request raised while busy is ignored
        @(negedge clk);
        req_valid = 1; req_write = 1; req_mask = 2'b11; req_addr = 15'h0100; req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1; req_addr = 15'h0200; req_wdata = 16'hDEAD;
        @(negedge clk);
        req_valid = 0;
        repeat (8) @(negedge clk);
        shadow[32'h100] = 16'hBEEF;
        do_op(0, 2'b11, 15'h0200, 16'h0, busy, rv_at, rd);
        check("R7 busy request ignored", {16'd0, rd}, 32'h0);
        do_op(0, 2'b11, 15'h0100, 16'h0, busy, rv_at, rd);
        check("R7 accepted write landed", {16'd0, rd}, 32'h0000BEEF);

        // R5/R2: read immediately followed by write, then read back
        do_op(0, 2'b11, 15'h0010, 16'h0, busy, rv_at, rd);
        check("R2 prior data", {16'd0, rd}, {16'd0, expect_rd(2'b11, 15'h0010)});
        do_op(1, 2'b11, 15'h0010, 16'hC3C3, busy, rv_at, rd);
        do_op(0, 2'b11, 15'h0010, 16'h0, busy, rv_at, rd);
        check("R5 turnaround write data", {16'd0, rd}, 32'h0000C3C3);
        check("R7 idle after access", 32'(req_ready), 32'd1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule